// File: doc/BRIEF.md
# Key-Guarded Power Control Register File

This block is a small bus-slave register file that sits between a peripheral bus and a power controller. It holds two protected registers: a power-mode register and a retention-memory control register. A third, write-only unlock register guards them. A protected register takes a bus write only when the write that came just before it on the bus was the exact unlock word. Any other write in between closes the gate again. This keeps a stray store from changing the power state.

The bus interface is single-cycle. A write happens on a rising clock edge while `bus_we` is high. Reads are combinational from `bus_addr`. The bus carries the writes for the whole peripheral bus, so writes to addresses this block does not own still count as intervening writes. The stored power mode and supply-monitor disable bit drive the power controller directly.

The unlock gate is a two-state machine:

- **LOCKED** is the reset state.
- **LOCKED → ARMED** happens on a write of the unlock word to the unlock register.
- **ARMED → ARMED** happens when the unlock word is written again.
- **ARMED → LOCKED** happens on any other write. This includes the accepted protected write, a write with a wrong unlock value, and a write to any other address.
- With no write, the state holds.

Register map (byte offsets on the bus):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | power-mode | bits 1:0 mode, bit 3 monitor disable |
| 0x04 | unlock | write-only |
| 0x08 | retention control | bits 1:0 |

Top module: `pwr_key_regs`

## Requirements
- R1: After reset the mode is 00, the monitor-disable bit is 0, the retention field is 00, and the gate is LOCKED, so an immediate protected write is ignored.
- R2: A read of the unlock register (offset 0x04), or of any unmapped offset, returns 0.
- R3: A write of exactly 0x00004859 (the full 32-bit word) to offset 0x04 moves the gate to ARMED. The next bus write, if it targets offset 0x00 or 0x08, is accepted.
- R4: While LOCKED, writes to offset 0x00 or 0x08 change neither the register contents nor the outputs.
- R5: A write to offset 0x04 with any value other than 0x00004859 leaves or puts the gate in LOCKED.
- R6: Any write to an offset other than 0x04 while ARMED returns the gate to LOCKED. This includes writes to addresses the block does not own.
- R7: An accepted protected write returns the gate to LOCKED, so a second protected write without a new unlock write is ignored.
- R8: The mode field is bits 1:0 of offset 0x00. Only code 00 (active) and code 10 (hibernate) are stored. On an accepted write carrying 01 or 11, the mode keeps its previous value, while bit 3 is still updated.
- R9: The power-mode register reads as {28'b0, mon_dis, 1'b0, mode}, and the retention register reads as {30'b0, ret}. All reserved bits read as 0 whatever was written.
- R10: `mode_o` and `mon_dis_o` follow the stored fields and change on the clock edge of the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| mode_o | output | 2 | Stored power mode to the power controller |
| mon_dis_o | output | 1 | Supply-monitor disable to the power controller |

## Verification
On every cycle, the assertions check four things:

- a cycle without an accepted write leaves both protected registers stable;
- the stored mode never holds a reserved code;
- every write other than the unlock word leaves the gate LOCKED;
- reserved read bits stay zero.

Some behaviour spans several writes and only the bench scenarios can show it: that the unlock word opens exactly one write, and that an intervening write or a wrong key defeats a later protected write. The bench covers these with directed sequences and a long random mix of writes checked against a reference model.

// File: rtl/pwr_key_pkg.sv
package pwr_key_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int MODE_W = 2;
    localparam int RET_W  = 2;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RET  = 8'h08;
    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0000_4859;
    localparam logic [MODE_W-1:0] MODE_ACTIVE = 2'b00;
    localparam logic [MODE_W-1:0] MODE_HIBER  = 2'b10;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } gate_state_t;
endpackage

// File: rtl/key_gate.sv
module key_gate
    import pwr_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_mode,
    output logic              wr_ret
);
    gate_state_t state_q, state_d;
    logic key_hit;

    assign key_hit = we && (addr == OFS_KEY) && (wdata == UNLOCK_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_hit) state_d = ST_ARMED;
            ST_ARMED:  if (we && !key_hit) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        wr_mode = 1'b0;
        wr_ret  = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                wr_mode = we && (addr == OFS_MODE);
                wr_ret  = we && (addr == OFS_RET);
            end
            default: ;
        endcase
    end

    // R5 R6
    non_key_write_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !key_hit) |=> (state_q == ST_LOCKED));

    // R7
    prot_write_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode || wr_ret) |=> (state_q == ST_LOCKED));
endmodule

// File: rtl/mode_reg.sv
module mode_reg
    import pwr_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              mon_dis_in,
    output logic [MODE_W-1:0] mode_q,
    output logic              mon_dis_q
);
    logic legal;

    assign legal = (mode_in == MODE_ACTIVE) || (mode_in == MODE_HIBER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_ACTIVE;
            mon_dis_q <= 1'b0;
        end else if (wr_en) begin
            mon_dis_q <= mon_dis_in;
            if (legal) mode_q <= mode_in;
        end
    end

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode_q) && $stable(mon_dis_q)));

    // R8
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE) || (mode_q == MODE_HIBER));
endmodule

// File: rtl/ret_reg.sv
module ret_reg
    import pwr_key_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RET_W-1:0] ret_in,
    output logic [RET_W-1:0] ret_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ret_q <= '0;
        else if (wr_en) ret_q <= ret_in;
    end

    // R4
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ret_q));
endmodule

// File: rtl/pwr_key_regs.sv
module pwr_key_regs
    import pwr_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [MODE_W-1:0] mode_o,
    output logic              mon_dis_o
);
    logic             wr_mode, wr_ret;
    logic [RET_W-1:0] ret_q;

    key_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wr_mode (wr_mode),
        .wr_ret  (wr_ret)
    );

    mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_mode),
        .mode_in    (bus_wdata[MODE_W-1:0]),
        .mon_dis_in (bus_wdata[3]),
        .mode_q     (mode_o),
        .mon_dis_q  (mon_dis_o)
    );

    ret_reg u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ret),
        .ret_in (bus_wdata[RET_W-1:0]),
        .ret_q  (ret_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_MODE: bus_rdata = {{(DATA_W-4){1'b0}}, mon_dis_o, 1'b0, mode_o};
            OFS_RET:  bus_rdata = {{(DATA_W-RET_W){1'b0}}, ret_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R9
    rdata_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:4] == '0) && !bus_rdata[2]);
endmodule

// File: tb/test_pwr_key_regs.sv
module test_pwr_key_regs;
    import pwr_key_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  mode_o;
    logic        mon_dis_o;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_mode;
    logic       m_mon;
    logic [1:0] m_ret;
    logic       m_armed;

    always #5 clk = ~clk;

    pwr_key_regs i_pwr_key_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o),
        .mon_dis_o(mon_dis_o)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {28'b0, m_mon, 1'b0, m_mode};
        if (a == 8'h08) return {30'b0, m_ret};
        return 32'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (m_armed && a == 8'h00) begin
            m_mon = d[3];
            if (d[1:0] == 2'b00 || d[1:0] == 2'b10) m_mode = d[1:0];
        end
        if (m_armed && a == 8'h08) m_ret = d[1:0];
        m_armed = (a == 8'h04) && (d == 32'h0000_4859);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic out_check(input string req);
        #1;
        check(req, {29'b0, mon_dis_o, mode_o}, {29'b0, m_mon, m_mode});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] addrs [4];
        m_mode = 2'b00; m_mon = 1'b0; m_ret = 2'b00; m_armed = 1'b0;
        addrs[0] = 8'h00; addrs[1] = 8'h04; addrs[2] = 8'h08; addrs[3] = 8'h20;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        out_check("R1 outputs");
        rd_check("R1 mode reg", 8'h00);
        rd_check("R1 ret reg", 8'h08);
        // R1 locked after reset, R4 locked write ignored
        wr(8'h00, 32'h0000_000A);
        out_check("R4 locked mode write");
        wr(8'h08, 32'h3);
        rd_check("R4 locked ret write", 8'h08);
        // R3 key then write
        wr(8'h04, 32'h0000_4859);
        wr(8'h00, 32'hFFFF_FFFE);
        out_check("R3 unlocked write R10");
        rd_check("R9 reserved bits zero", 8'h00);
        // R2 key read
        rd_check("R2 key read", 8'h04);
        rd_check("R2 unmapped read", 8'h40);
        // R7 double write after single key
        wr(8'h04, 32'h0000_4859);
        wr(8'h08, 32'hFFFF_FFF2);
        rd_check("R3 ret write", 8'h08);
        wr(8'h08, 32'h1);
        rd_check("R7 second write ignored", 8'h08);
        // R6 intervening write
        wr(8'h04, 32'h0000_4859);
        wr(8'h30, 32'h0);
        wr(8'h00, 32'h0);
        out_check("R6 relock after other write");
        // R5 wrong keys
        wr(8'h04, 32'h0000_4858);
        wr(8'h00, 32'h0);
        out_check("R5 wrong key");
        wr(8'h04, 32'h0001_4859);
        wr(8'h08, 32'h0);
        rd_check("R5 upper bits in key", 8'h08);
        // R8 reserved mode codes
        wr(8'h04, 32'h0000_4859);
        wr(8'h00, 32'h0000_0001);
        out_check("R8 reserved code 01");
        wr(8'h04, 32'h0000_4859);
        wr(8'h00, 32'h0000_000B);
        out_check("R8 reserved code 11");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = addrs[$urandom_range(0, 3)];
            d = ($urandom_range(0, 2) == 0) ? 32'h0000_4859 : $urandom;
            if ($urandom_range(0, 1) == 0) d = d & 32'hF;
            wr(a, d);
            out_check("R10 random outputs");
            if (i % 8 == 0) begin
                rd_check("R9 random mode read", 8'h00);
                rd_check("R9 random ret read", 8'h08);
                model_write(8'hFF, 32'h0);
                wr(8'hFF, 32'h0);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule